// File: doc/BRIEF.md
# Edge-Selectable Trigger Event Combiner

This block watches a bank of single-bit timing signals, such as PWM reload and edge marks, timer outputs and an external pin. It turns chosen transitions on those signals into strobes for a downstream trigger sequencer. Each source has its own 2-bit edge mode that selects rising, falling or both transitions, or turns detection off. Each source also has its own enable bit, which admits its detected edges into a single merged event strobe.

A separate select field names one source whose detected edges are forwarded as a master reload strobe. This happens whatever that source's enable bit says. When the selected source is also enabled, its edge shows up on both outputs in the same cycle, so the reload that opens a period also counts as that period's first event. Both strobes are registered and one clock wide per detected edge.

All inputs are taken to be synchronous to `clk`. Configuration arrives as plain ports that a register file drives elsewhere.

Top module: `trig_event_combiner`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `event_o` and `reload_o` are both 0.
- R2: Source i uses mode bits `edge_mode[2i+1:2i]`. Code 01 (bit 0 set) detects only 0-to-1 transitions of `src_in[i]`.
- R3: Mode code 10 (bit 1 set) detects only 1-to-0 transitions of `src_in[i]`.
- R4: Mode code 11 detects both transitions of `src_in[i]`.
- R5: Mode code 00 detects nothing. Toggling that source drives neither `event_o` nor `reload_o`.
- R6: A source whose `src_en[i]` bit is 0 never causes `event_o`, even when its edge is detected.
- R7: Detected edges of all enabled sources are ORed together. Edges on several enabled sources in the same cycle give a single one-cycle `event_o` pulse.
- R8: `reload_o` pulses for detected edges of source number `reload_sel` only, whatever that source's enable bit is. A `reload_sel` value of `N_SRC` or above never produces `reload_o`.
- R9: When the reload source is enabled, each of its detected edges pulses `reload_o` and `event_o` in the same cycle.
- R10: An input transition that is present before a rising clock edge appears on the outputs just after that edge. The output is one cycle wide per detected edge, and transitions on consecutive cycles give consecutive pulses.
- R11: An input that is already high when reset is released is not reported as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | N_SRC | Synchronous timing source signals |
| src_en | input | N_SRC | Per-source enable into the merged event strobe |
| edge_mode | input | 2*N_SRC | Per-source edge mode, 2 bits per source (00 off, 01 rise, 10 fall, 11 both) |
| reload_sel | input | SEL_W | Index of the source that drives the master reload strobe |
| event_o | output | 1 | Merged event strobe, one cycle per detection |
| reload_o | output | 1 | Master reload strobe |

## Verification
The in-line assertions check several rules on every cycle. A reload on an enabled source always carries an event with it. An out-of-range select or an all-off mode vector keeps the strobes low. No strobe appears without an enabled source having changed. Nothing fires in the warm-up cycle after reset. Only the directed scenarios can show that each edge mode picks the correct polarity, that simultaneous edges collapse into one pulse, that back-to-back toggles give back-to-back pulses, and that a disabled source can still drive the reload.

// File: rtl/trig_event_combiner.sv
module trig_event_combiner #(
  parameter int N_SRC = 16,
  parameter int SEL_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_in,
  input  logic [N_SRC-1:0]   src_en,
  input  logic [2*N_SRC-1:0] edge_mode,
  input  logic [SEL_W-1:0]   reload_sel,
  output logic               event_o,
  output logic               reload_o
);

  logic [N_SRC-1:0] prev_q;
  logic             primed_q;
  logic [N_SRC-1:0] rise, fall, hit;
  logic             sel_hit, sel_en, sel_oor;

  assign rise = src_in & ~prev_q;
  assign fall = ~src_in & prev_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_det
    assign hit[g] = primed_q & ((edge_mode[2*g] & rise[g]) | (edge_mode[2*g+1] & fall[g]));
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_en  = 1'b0;
    sel_oor = 1'b1;
    for (int i = 0; i < N_SRC; i++) begin
      if (reload_sel == SEL_W'(i)) begin
        sel_hit = hit[i];
        sel_en  = src_en[i];
        sel_oor = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      event_o  <= 1'b0;
      reload_o <= 1'b0;
    end else begin
      prev_q   <= src_in;
      primed_q <= 1'b1;
      event_o  <= |(hit & src_en);
      reload_o <= sel_hit;
    end
  end

  // R9
  reload_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o && $past(sel_en) |-> event_o);

  // R8
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_oor) |-> !reload_o);

  // R5
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(edge_mode == '0) |-> !event_o && !reload_o);

  // R6
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src_en == '0) |-> !event_o);

  // R11
  warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(primed_q) |-> !event_o && !reload_o);

  // R10
  event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(((src_in ^ prev_q) & src_en) != '0));

endmodule

// File: tb/trig_event_combiner_bench.sv
module trig_event_combiner_bench;
  localparam int N = 16;
  localparam int SW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   src_in = '0;
  logic [N-1:0]   src_en = '0;
  logic [2*N-1:0] edge_mode = '0;
  logic [SW-1:0]  reload_sel = '0;
  logic event_o, reload_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_event_combiner #(.N_SRC(N), .SEL_W(SW)) u_trig_event_combiner (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_en(src_en),
    .edge_mode(edge_mode), .reload_sel(reload_sel),
    .event_o(event_o), .reload_o(reload_o));

  task automatic check(input string tag, input logic ev, input logic rl);
    n_chk++;
    if (event_o !== ev || reload_o !== rl) begin
      n_bad++;
      $display("FAIL %s: event/reload actual %b/%b expected %b/%b", tag, event_o, reload_o, ev, rl);
    end
  endtask

  task automatic step(input logic [N-1:0] nxt, input logic ev, input logic rl, input string tag);
    @(negedge clk);
    src_in = nxt;
    @(posedge clk);
    #1;
    check(tag, ev, rl);
  endtask

  task automatic setup(input int idx, input logic [1:0] m, input logic en, input int sel);
    @(negedge clk);
    edge_mode = '0;
    src_en = '0;
    edge_mode[2*idx +: 2] = m;
    src_en[idx] = en;
    reload_sel = SW'(sel);
  endtask

  task automatic t_reset;
    src_in = '1;
    src_en = '1;
    edge_mode = '1;
    #1;
    check("R1 in reset", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 first cycle", 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R11 high input at release", 1'b0, 1'b0);
    @(negedge clk);
    edge_mode = '0;
    src_en = '0;
    src_in = '0;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_rise;
    setup(0, 2'b01, 1'b1, 0);
    step(16'h0001, 1'b1, 1'b1, "R2 R9 rising edge");
    step(16'h0001, 1'b0, 1'b0, "R10 pulse width");
    step(16'h0000, 1'b0, 1'b0, "R2 falling ignored");
  endtask

  task automatic t_fall;
    setup(3, 2'b10, 1'b1, 3);
    step(16'h0008, 1'b0, 1'b0, "R3 rising ignored");
    step(16'h0000, 1'b1, 1'b1, "R3 falling edge");
    step(16'h0000, 1'b0, 1'b0, "R10 pulse ends");
  endtask

  task automatic t_both;
    setup(5, 2'b11, 1'b1, 20);
    step(16'h0020, 1'b1, 1'b0, "R4 R8 rise, select out of range");
    step(16'h0000, 1'b1, 1'b0, "R4 R10 fall next cycle");
    step(16'h0020, 1'b1, 1'b0, "R10 back-to-back edge");
    step(16'h0020, 1'b0, 1'b0, "R10 idle after burst");
    step(16'h0000, 1'b1, 1'b0, "R4 fall");
  endtask

  task automatic t_off;
    setup(7, 2'b00, 1'b1, 7);
    step(16'h0080, 1'b0, 1'b0, "R5 mode off rise");
    step(16'h0000, 1'b0, 1'b0, "R5 mode off fall");
  endtask

  task automatic t_disabled;
    setup(9, 2'b01, 1'b0, 9);
    step(16'h0200, 1'b0, 1'b1, "R6 R8 disabled source drives reload only");
    step(16'h0000, 1'b0, 1'b0, "R6 idle");
  endtask

  task automatic t_merge;
    @(negedge clk);
    edge_mode = '0;
    src_en = '0;
    edge_mode[2*1 +: 2] = 2'b01;
    edge_mode[2*2 +: 2] = 2'b01;
    edge_mode[2*4 +: 2] = 2'b01;
    src_en[1] = 1'b1;
    src_en[2] = 1'b1;
    src_en[4] = 1'b1;
    reload_sel = SW'(2);
    step(16'h0016, 1'b1, 1'b1, "R7 simultaneous edges");
    step(16'h0016, 1'b0, 1'b0, "R7 single pulse");
    step(16'h0006, 1'b0, 1'b0, "R7 falls ignored");
    step(16'h0016, 1'b1, 1'b0, "R7 R8 non-selected source event");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_disabled();
    t_merge();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule